// File: doc/BRIEF.md
# Frame-Buffer Pixel Unpacker with Palette Lookup

This block sits between a frame-buffer fetch queue and a display timing generator. It takes 32-bit words through a valid/ready input. For each pixel request from the timing side, it returns one 24-bit colour one cycle later. Pixel depths of 1, 2, 4 and 8 bits are indices into a 256-entry colour table, which is loaded through a simple write port. A 16-bit pixel is expanded from one of two 5/6-bit channel layouts. A 24-bit pixel passes straight through and is stored either one per word or packed four to a group of three words.

Each incoming word can have its bytes reversed. Pixels can be taken from the low end or the high end of a word (or of a packed group). A new word is taken only when every pixel of the held word or group has been used. It may be taken in the same cycle as the last of those pixels. If a pixel is requested while no complete word or group is held, the block returns black and does not stall the request. It also raises a sticky underflow flag, which a clear input resets.

The configuration inputs are expected to stay unchanged between resets while data is in flight.

Top module: `fb_pixel_unpacker`

## Requirements
- R1: After reset, in_ready is 1, pix_valid is 0, pix_out is 0 and underflow is 0.
- R2: With pal_we high, pal_wdata is stored at entry pal_addr. Entries hold red in bits 7:0, green in bits 15:8 and blue in bits 23:16. In index modes a pixel's value n returns entry n unchanged on pix_out, which uses the same channel layout.
- R3: cfg_bpp selects the depth: code 0 is 1 bit, 1 is 2 bits, 2 is 4 bits, 3 is 8 bits, 4 is 16 bits and 5 is 24 bits. Codes 0 to 3 are palette indices, giving 32, 16, 8 and 4 pixels per word.
- R4: cfg_order 0 (and reserved code 3) keeps byte order. Pixel k of a word occupies bits [k*w + w-1 : k*w], where w is the pixel width.
- R5: cfg_order 2 keeps byte order and takes pixels from the top: pixel k of a word occupies bits [31-k*w : 32-(k+1)*w]. cfg_order 1 first reverses the four bytes of every accepted word, then orders pixels as code 2 does.
- R6: In 16-bit mode with cfg_rgb565=1, red is field bits 15:11, green is 10:5 and blue is 4:0. Each channel is widened to 8 bits by appending its own top bits (5-bit v becomes {v, v[4:2]}; 6-bit v becomes {v, v[5:4]}). Two pixels come from each word.
- R7: In 16-bit mode with cfg_rgb565=0, blue is field bits 15:11, green is 10:6 (5 bits) and red is 5:0 (6 bits). The channels are widened as in R6.
- R8: In 24-bit mode with cfg_pack24=0, each word carries one pixel. pix_out is bits 23:0 of the (byte-ordered) word, and the palette is bypassed.
- R9: In 24-bit mode with cfg_pack24=1, three words carry four pixels. In low-first order, pixel k is bits [24k+23:24k] of {w2,w1,w0}. In high-first order, pixel k is bits [95-24k:72-24k] of {w0,w1,w2}, where w0 is the first word accepted.
- R10: in_ready is 1 when the block holds no complete word or group. It is also 1 in a cycle where a request consumes the last pixel of the held data, and the word accepted then becomes the first of the next container. Otherwise in_ready is 0.
- R11: A request made while no complete word or group is held gives pix_out = 0 with pix_valid = 1 in the next cycle. It sets underflow and does not advance the pixel position.
- R12: underflow stays set until a cycle with uf_clr high and no new underflow. A new underflow takes priority over the clear.
- R13: pix_valid is 1 exactly in the cycle after each cycle with pix_req high, and pix_out carries that request's pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_bpp | input | 3 | Pixel depth code |
| cfg_rgb565 | input | 1 | 16-bit layout select: 1 for 5-6-5 with red at the top, 0 for 5-5-6 with blue at the top |
| cfg_pack24 | input | 1 | 24-bit packing: 1 for four pixels per three words |
| cfg_order | input | 2 | Byte and pixel order code |
| in_data | input | 32 | Frame-buffer word |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Word is accepted when in_valid and in_ready are both high |
| pix_req | input | 1 | Pixel request from the timing generator |
| pix_valid | output | 1 | pix_out holds the pixel for the previous cycle's request |
| pix_out | output | 24 | Pixel colour: red 7:0, green 15:8, blue 23:16 |
| underflow | output | 1 | Sticky flag: a pixel was requested with no data held |
| uf_clr | input | 1 | Clears underflow |
| pal_we | input | 1 | Colour table write strobe |
| pal_addr | input | 8 | Colour table write entry |
| pal_wdata | input | 24 | Colour table write data |

## Verification
Most internal faults here show up on the very next returned pixel. A wrong pixel position or fill count shifts every later pixel. A miscounted container end makes in_ready rise a cycle early or late, and the bench compares in_ready against its own model in every cycle, so that cycle is flagged directly. A wrong byte or pixel order, a swapped 16-bit layout, or a wrongly spliced packed group shows as a wrong colour on the first pixel that uses the faulty bits. The model therefore predicts every pixel for randomised word and request patterns in each mode and order. A lost or stuck underflow state shows in the flag within one cycle of a starved request or a clear.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

  localparam logic [2:0] DEPTH_1  = 3'd0;
  localparam logic [2:0] DEPTH_2  = 3'd1;
  localparam logic [2:0] DEPTH_4  = 3'd2;
  localparam logic [2:0] DEPTH_8  = 3'd3;
  localparam logic [2:0] DEPTH_16 = 3'd4;
  localparam logic [2:0] DEPTH_24 = 3'd5;

  localparam int IDX_W = 5;

  typedef struct packed {
    logic [7:0] blu;
    logic [7:0] grn;
    logic [7:0] red;
  } rgb_t;

  function automatic logic [4:0] depth_bits(input logic [2:0] code);
    case (code)
      DEPTH_1:  depth_bits = 5'd1;
      DEPTH_2:  depth_bits = 5'd2;
      DEPTH_4:  depth_bits = 5'd4;
      DEPTH_8:  depth_bits = 5'd8;
      DEPTH_16: depth_bits = 5'd16;
      default:  depth_bits = 5'd24;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] final_pos(input logic [2:0] code, input logic packed24);
    case (code)
      DEPTH_1:  final_pos = 5'd31;
      DEPTH_2:  final_pos = 5'd15;
      DEPTH_4:  final_pos = 5'd7;
      DEPTH_8:  final_pos = 5'd3;
      DEPTH_16: final_pos = 5'd1;
      default:  final_pos = packed24 ? 5'd3 : 5'd0;
    endcase
  endfunction

  function automatic logic [7:0] widen5(input logic [4:0] v);
    widen5 = {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] v);
    widen6 = {v, v[5:4]};
  endfunction

endpackage

// File: rtl/pxu_word_buf.sv
module pxu_word_buf #(
  parameter int WORD_W = 32,
  parameter int SLOTS  = 3,
  parameter int IDX_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WORD_W-1:0]       in_data,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    pix_req,
  input  logic                    use_group,
  input  logic                    swap_bytes,
  input  logic [IDX_W-1:0]        last_pos,
  output logic                    full,
  output logic [IDX_W-1:0]        pos,
  output logic [SLOTS*WORD_W-1:0] grp
);

  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam int NBYTE = WORD_W / 8;

  logic [CNT_W-1:0]  fill_q, fill_d;
  logic [IDX_W-1:0]  pos_q, pos_d;
  logic [CNT_W-1:0]  need;
  logic [CNT_W-1:0]  wr_ptr;
  logic [WORD_W-1:0] word_in;
  logic              at_end, drain, accept, consume;
  logic [WORD_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  slot_we;

  genvar gb;
  generate
    for (gb = 0; gb < NBYTE; gb++) begin : g_swap
      assign word_in[gb*8 +: 8] = swap_bytes ? in_data[(NBYTE-1-gb)*8 +: 8]
                                             : in_data[gb*8 +: 8];
    end
  endgenerate

  always_comb begin
    need     = use_group ? CNT_W'(SLOTS) : CNT_W'(1);
    full     = (fill_q == need);
    at_end   = (pos_q == last_pos);
    consume  = pix_req && full;
    drain    = consume && at_end;
    in_ready = !full || drain;
    accept   = in_valid && in_ready;
    wr_ptr   = drain ? '0 : fill_q;
  end

  always_comb begin
    fill_d = fill_q;
    if (drain)       fill_d = accept ? CNT_W'(1) : '0;
    else if (accept) fill_d = fill_q + CNT_W'(1);
    pos_d = pos_q;
    if (consume)     pos_d = at_end ? '0 : pos_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      pos_q  <= '0;
    end else begin
      fill_q <= fill_d;
      pos_q  <= pos_d;
    end
  end

  genvar gs;
  generate
    for (gs = 0; gs < SLOTS; gs++) begin : g_slot
      assign slot_we[gs] = accept && (wr_ptr == CNT_W'(gs));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           slot_q[gs] <= '0;
        else if (slot_we[gs]) slot_q[gs] <= word_in;
      end
      assign grp[gs*WORD_W +: WORD_W] = slot_q[gs];
    end
  endgenerate

  assign pos = pos_q;

  // R10: a held container is kept intact until requests use it up
  a_r10_keep_full: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pix_req |=> full && $stable(grp));

  // R10: the last pixel with no word offered leaves the buffer empty
  a_r10_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
    full && pix_req && at_end && !in_valid |=> !full);

  // R11: a starved request does not move the pixel position
  a_r11_hold_pos: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req && !full |=> $stable(pos));

endmodule

// File: rtl/pxu_extract.sv
module pxu_extract #(
  parameter int WORD_W = 32,
  parameter int SLOTS  = 3,
  parameter int PIX_W  = 24,
  parameter int IDX_W  = 5
) (
  input  logic [SLOTS*WORD_W-1:0] grp,
  input  logic [2:0]              depth,
  input  logic                    packed24,
  input  logic                    high_first,
  input  logic [IDX_W-1:0]        pos,
  output logic [PIX_W-1:0]        field
);
  import pxu_pkg::*;

  localparam int GRP_W = SLOTS * WORD_W;
  localparam int SH_W  = $clog2(GRP_W) + 1;

  logic [GRP_W-1:0] rev_grp;
  logic [4:0]       w;
  logic [SH_W-1:0]  sh;
  logic [PIX_W-1:0] lo_pick, hi_pick, raw;
  logic [PIX_W:0]   mask;

  genvar gi;
  generate
    for (gi = 0; gi < SLOTS; gi++) begin : g_rev
      assign rev_grp[(SLOTS-1-gi)*WORD_W +: WORD_W] = grp[gi*WORD_W +: WORD_W];
    end
  endgenerate

  always_comb begin
    w       = depth_bits(depth);
    sh      = SH_W'(pos) * SH_W'(w);
    lo_pick = PIX_W'(grp >> sh);
    hi_pick = PIX_W'((rev_grp << sh) >> (GRP_W - PIX_W));
    hi_pick = hi_pick >> (SH_W'(PIX_W) - SH_W'(w));
    mask    = ({{PIX_W{1'b0}}, 1'b1} << w) - (PIX_W+1)'(1);
    raw     = high_first ? hi_pick : lo_pick;
    field   = raw & mask[PIX_W-1:0];
    if (depth >= DEPTH_24 && !packed24) field = grp[PIX_W-1:0];
  end

endmodule

// File: rtl/pxu_palette.sv
module pxu_palette #(
  parameter int DEPTH = 256,
  parameter int DW    = 24,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R2: a written entry holds the written colour in the next cycle
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/pxu_color.sv
module pxu_color #(
  parameter int PIX_W = 24,
  parameter int AW    = 8
) (
  input  logic [PIX_W-1:0] field,
  input  logic [2:0]       depth,
  input  logic             rgb565,
  input  logic [PIX_W-1:0] pal_rdata,
  output logic [AW-1:0]    pal_raddr,
  output logic [PIX_W-1:0] rgb
);
  import pxu_pkg::*;

  rgb_t c;

  assign pal_raddr = field[AW-1:0];

  always_comb begin
    c = rgb_t'(field);
    if (depth <= DEPTH_8) begin
      c = rgb_t'(pal_rdata);
    end else if (depth == DEPTH_16) begin
      if (rgb565) begin
        c.red = widen5(field[15:11]);
        c.grn = widen6(field[10:5]);
        c.blu = widen5(field[4:0]);
      end else begin
        c.blu = widen5(field[15:11]);
        c.grn = widen5(field[10:6]);
        c.red = widen6(field[5:0]);
      end
    end
    rgb = c;
  end

endmodule

// File: rtl/fb_pixel_unpacker.sv
module fb_pixel_unpacker #(
  parameter int WORD_W    = 32,
  parameter int PIX_W     = 24,
  parameter int PAL_DEPTH = 256,
  parameter int PAL_AW    = $clog2(PAL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_bpp,
  input  logic              cfg_rgb565,
  input  logic              cfg_pack24,
  input  logic [1:0]        cfg_order,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              pix_req,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_out,
  output logic              underflow,
  input  logic              uf_clr,
  input  logic              pal_we,
  input  logic [PAL_AW-1:0] pal_addr,
  input  logic [PIX_W-1:0]  pal_wdata
);
  import pxu_pkg::*;

  localparam int SLOTS = 3;

  logic                    rs0_q, rs1_q, rst_sync_n;
  logic                    use_group, swap_bytes, high_first;
  logic [IDX_W-1:0]        last_pos, pos;
  logic                    buf_full;
  logic [SLOTS*WORD_W-1:0] grp;
  logic [PIX_W-1:0]        field, pal_rdata, rgb;
  logic [PAL_AW-1:0]       pal_raddr;
  logic                    valid_q, valid_d;
  logic [PIX_W-1:0]        out_q, out_d;
  logic                    uf_q, uf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_sync_n = rs1_q;

  always_comb begin
    use_group  = (cfg_bpp >= DEPTH_24) && cfg_pack24;
    swap_bytes = (cfg_order == 2'd1);
    high_first = (cfg_order == 2'd1) || (cfg_order == 2'd2);
    last_pos   = final_pos(cfg_bpp, cfg_pack24);
  end

  pxu_word_buf #(.WORD_W(WORD_W), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .pix_req    (pix_req),
    .use_group  (use_group),
    .swap_bytes (swap_bytes),
    .last_pos   (last_pos),
    .full       (buf_full),
    .pos        (pos),
    .grp        (grp)
  );

  pxu_extract #(.WORD_W(WORD_W), .SLOTS(SLOTS), .PIX_W(PIX_W), .IDX_W(IDX_W)) u_ext (
    .grp        (grp),
    .depth      (cfg_bpp),
    .packed24   (cfg_pack24),
    .high_first (high_first),
    .pos        (pos),
    .field      (field)
  );

  pxu_palette #(.DEPTH(PAL_DEPTH), .DW(PIX_W), .AW(PAL_AW)) u_pal (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (pal_we),
    .waddr (pal_addr),
    .wdata (pal_wdata),
    .raddr (pal_raddr),
    .rdata (pal_rdata)
  );

  pxu_color #(.PIX_W(PIX_W), .AW(PAL_AW)) u_col (
    .field     (field),
    .depth     (cfg_bpp),
    .rgb565    (cfg_rgb565),
    .pal_rdata (pal_rdata),
    .pal_raddr (pal_raddr),
    .rgb       (rgb)
  );

  always_comb begin
    valid_d = pix_req;
    out_d   = out_q;
    if (pix_req) out_d = buf_full ? rgb : '0;
    uf_d = uf_q;
    if (pix_req && !buf_full) uf_d = 1'b1;
    else if (uf_clr)          uf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      out_q   <= '0;
      uf_q    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      out_q   <= out_d;
      uf_q    <= uf_d;
    end
  end

  assign pix_valid = valid_q;
  assign pix_out   = out_q;
  assign underflow = uf_q;

  // R11: a starved request returns black and raises the flag
  a_r11_zero_on_starve: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pix_req && !buf_full |=> pix_valid && (pix_out == '0) && underflow);

  // R12: the flag holds until cleared
  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    underflow && !uf_clr |=> underflow);

  // R10: an empty buffer always offers to take a word
  a_r10_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !buf_full |-> in_ready);

endmodule

// File: tb/fb_pixel_unpacker_tb.sv
`timescale 1ns/1ps
module fb_pixel_unpacker_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_bpp;
  logic        cfg_rgb565, cfg_pack24;
  logic [1:0]  cfg_order;
  logic [31:0] in_data;
  logic        in_valid, in_ready, pix_req, pix_valid;
  logic [23:0] pix_out;
  logic        underflow, uf_clr, pal_we;
  logic [7:0]  pal_addr;
  logic [23:0] pal_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [23:0] pal_m [256];
  logic [31:0] mw [3];
  int          mfill, midx;
  bit          m_uf;
  logic [23:0] m_out;
  string       ptag;

  always #2.5 clk = ~clk;

  fb_pixel_unpacker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_bpp(cfg_bpp), .cfg_rgb565(cfg_rgb565),
    .cfg_pack24(cfg_pack24), .cfg_order(cfg_order), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .pix_req(pix_req),
    .pix_valid(pix_valid), .pix_out(pix_out), .underflow(underflow),
    .uf_clr(uf_clr), .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int width_m();
    if (cfg_bpp <= 3'd4) return 1 << cfg_bpp;
    return 24;
  endfunction

  function automatic int per_container();
    if (cfg_bpp >= 3'd5) return cfg_pack24 ? 4 : 1;
    return 32 / width_m();
  endfunction

  function automatic logic [7:0] x5(input int v);
    return 8'((v * 8) + (v / 4));
  endfunction

  function automatic logic [7:0] x6(input int v);
    return 8'((v * 4) + (v / 16));
  endfunction

  function automatic logic [23:0] model_pix(input int k);
    int b;
    logic [95:0] lo, hi;
    logic [23:0] f;
    b  = width_m();
    lo = {mw[2], mw[1], mw[0]};
    hi = {mw[0], mw[1], mw[2]};
    f  = '0;
    if (cfg_bpp >= 3'd5 && !cfg_pack24) f = mw[0][23:0];
    else begin
      for (int j = 0; j < b; j++) begin
        if (cfg_order == 2'd1 || cfg_order == 2'd2) f[b-1-j] = hi[95-(k*b+j)];
        else                                         f[j]     = lo[k*b+j];
      end
    end
    if (cfg_bpp <= 3'd3) return pal_m[f[7:0]];
    if (cfg_bpp == 3'd4) begin
      if (cfg_rgb565) return {x5(int'(f[4:0])), x6(int'(f[10:5])), x5(int'(f[15:11]))};
      return {x5(int'(f[15:11])), x5(int'(f[10:6])), x6(int'(f[5:0]))};
    end
    return f;
  endfunction

  task automatic tick();
    int need, ppc;
    bit full, last, drain, rdy, acc, ev, euf;
    logic [23:0] eo;
    logic [31:0] w;
    need  = (cfg_bpp >= 3'd5 && cfg_pack24) ? 3 : 1;
    ppc   = per_container();
    full  = (mfill == need);
    last  = (midx == ppc - 1);
    drain = pix_req && full && last;
    rdy   = !full || drain;
    acc   = in_valid && rdy;
    #1;
    if (rst_n) chk({31'd0, in_ready}, {31'd0, rdy}, "R10", "in_ready");
    ev  = pix_req;
    eo  = full ? model_pix(midx) : 24'd0;
    euf = (pix_req && !full) ? 1'b1 : (uf_clr ? 1'b0 : m_uf);
    w   = in_data;
    if (cfg_order == 2'd1) w = {in_data[7:0], in_data[15:8], in_data[23:16], in_data[31:24]};
    @(posedge clk);
    if (ev) m_out = eo;
    m_uf = euf;
    if (pix_req && full) midx = last ? 0 : midx + 1;
    if (drain) begin
      mfill = 0;
      if (acc) begin mw[0] = w; mfill = 1; end
    end else if (acc) begin
      mw[mfill] = w;
      mfill++;
    end
    if (pal_we) pal_m[pal_addr] = pal_wdata;
    @(negedge clk);
    chk({31'd0, pix_valid}, {31'd0, ev}, "R13", "pix_valid");
    if (ev) chk({8'd0, pix_out}, {8'd0, eo}, full ? ptag : "R11", "pix_out");
    chk({31'd0, underflow}, {31'd0, m_uf}, "R12", "underflow");
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 0; pix_req = 0; uf_clr = 0; pal_we = 0;
    in_data = '0; pal_addr = '0; pal_wdata = '0;
    mfill = 0; midx = 0; m_uf = 0; m_out = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();
    chk({31'd0, in_ready}, 32'd1, "R1", "in_ready after reset");
    chk({31'd0, pix_valid}, 32'd0, "R1", "pix_valid after reset");
    chk({8'd0, pix_out}, 32'd0, "R1", "pix_out after reset");
    chk({31'd0, underflow}, 32'd0, "R1", "underflow after reset");
  endtask

  task automatic run_phase(input logic [2:0] b, input logic sel565, input logic pk,
                           input logic [1:0] ord, input string tag, input int cyc,
                           input int vpct, input int rpct);
    cfg_bpp = b; cfg_rgb565 = sel565; cfg_pack24 = pk; cfg_order = ord; ptag = tag;
    do_reset();
    for (int i = 0; i < cyc; i++) begin
      in_valid = (($urandom % 100) < vpct);
      in_data  = $urandom;
      pix_req  = (($urandom % 100) < rpct);
      uf_clr   = (($urandom % 100) < 8);
      tick();
    end
    in_valid = 0; pix_req = 0; uf_clr = 0;
  endtask

  initial begin
    cfg_bpp = 3'd3; cfg_rgb565 = 1; cfg_pack24 = 0; cfg_order = 0; ptag = "R1";
    do_reset();
    // R2: load the whole colour table with a computed pattern
    for (int i = 0; i < 256; i++) begin
      pal_we    = 1'b1;
      pal_addr  = 8'(i);
      pal_wdata = {8'(i ^ 8'h5A), 8'(255 - i), 8'(i * 7 + 3)};
      tick();
    end
    pal_we = 1'b0;
    // index modes, low-first order (R2 R3 R4)
    run_phase(3'd0, 1, 0, 2'd0, "R2 R3 R4", 500, 70, 70);
    run_phase(3'd1, 1, 0, 2'd0, "R2 R3 R4", 400, 70, 70);
    run_phase(3'd2, 1, 0, 2'd0, "R2 R3 R4", 400, 70, 70);
    run_phase(3'd3, 1, 0, 2'd0, "R2 R3 R4", 400, 70, 60);
    run_phase(3'd3, 1, 0, 2'd3, "R2 R3 R4", 200, 70, 60);
    // index modes, high-first and byte-swapped orders (R5)
    run_phase(3'd3, 1, 0, 2'd1, "R2 R3 R5", 400, 70, 60);
    run_phase(3'd0, 1, 0, 2'd2, "R2 R3 R5", 400, 70, 70);
    run_phase(3'd2, 1, 0, 2'd1, "R2 R3 R5", 400, 70, 70);
    // 16-bit layouts (R6 R7)
    run_phase(3'd4, 1, 0, 2'd0, "R6 R4", 400, 70, 60);
    run_phase(3'd4, 1, 0, 2'd1, "R6 R5", 400, 70, 60);
    run_phase(3'd4, 0, 0, 2'd0, "R7 R4", 400, 70, 60);
    run_phase(3'd4, 0, 0, 2'd2, "R7 R5", 400, 70, 60);
    // 24-bit unpacked and packed (R8 R9)
    run_phase(3'd5, 1, 0, 2'd0, "R8", 400, 80, 50);
    run_phase(3'd5, 1, 0, 2'd1, "R8 R5", 400, 80, 50);
    run_phase(3'd5, 1, 1, 2'd0, "R9", 500, 85, 40);
    run_phase(3'd5, 1, 1, 2'd2, "R9 R5", 500, 85, 40);
    run_phase(3'd5, 1, 1, 2'd1, "R9 R5", 500, 85, 40);
    // starvation and flag clearing (R11 R12)
    run_phase(3'd3, 1, 0, 2'd0, "R11", 150, 0, 60);
    run_phase(3'd4, 1, 0, 2'd0, "R12 R6", 400, 20, 80);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule